// File: doc/BRIEF.md
# Priority-Limited FIFO Allocation Router

The router hands out four shared FIFO buffers to four port units. A port presents a request together with the number of words it wants to move. The router looks up the level that the host has assigned to that port, restricts the search to the FIFOs that level may use, and answers with one of three outcomes:

- a full grant in the first permitted FIFO with enough room;
- a partial grant in the permitted FIFO with the most room;
- a wait, when nothing is available.

A granted FIFO belongs to its port until the port signals that it has finished. The FIFO storage and the serial links sit outside this block: the router sees only the free-word count of each FIFO.

Levels run from 0 (highest) to 3 (lowest). The FIFO index is also the FIFO's level. A port at level p may therefore use FIFOs 0 through p.

The host sets each port's level through a one-cycle write strobe that carries an address and data. Requests waiting at the same time are answered one per cycle.

Top module: `fifo_alloc_router`

## Requirements
- R1: Every port level resets to 3. A cycle with `cfg_we_i` high loads `cfg_data_i` into the level of port `cfg_addr_i`. The new level governs every request arbitrated from the following cycle onward.
- R2: A port whose level is p is granted only FIFOs with index 0 to p.
- R3: The permitted FIFOs are scanned from index 0 upward. The first eligible FIFO whose free count is at least the requested count is granted in full. The response is code 2'b01, that FIFO's index, and the requested count.
- R4: When no eligible FIFO fits the request but at least one eligible FIFO exists, the grant is partial. The router picks the eligible FIFO with the largest free count, taking the lowest index on a tie. The response is code 2'b10, that index, and that FIFO's free count.
- R5: When no permitted FIFO is eligible, the response is code 2'b11 with FIFO index 0 and count 0. Nothing is allocated.
- R6: A FIFO is eligible only if its free count is at least 1 and no port currently holds it.
- R7: At most one port receives a response per cycle. Among the pending ports, the lowest-numbered one is served first. The response is a single-cycle pulse on that port's bit of `rsp_valid_o`, in the cycle after the request is sampled. A request still high during its response cycle is not arbitrated again.
- R8: A granted FIFO stays held until its owner raises `done_i`. It becomes eligible again from the cycle after `done_i` is sampled.
- R9: A request from a port that already holds a FIFO receives no response until that FIFO has been released.
- R10: After reset no response is valid, no FIFO is held, and the code, index and count fields of every port read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 4 | Per-port request, held until the response pulse |
| req_count_i | input | 48 | Per-port requested word count, 12 bits per port, port p at bits [12p+11:12p] |
| done_i | input | 4 | Per-port release of the FIFO the port holds |
| fifo_free_i | input | 48 | Free words of each FIFO, 12 bits per FIFO, FIFO f at bits [12f+11:12f] |
| cfg_we_i | input | 1 | Host level write strobe |
| cfg_addr_i | input | 2 | Port whose level is written |
| cfg_data_i | input | 2 | Level value written |
| rsp_valid_o | output | 4 | One-cycle response pulse per port |
| rsp_code_o | output | 8 | Per-port code, 2 bits per port: 01 full, 10 partial, 11 wait, 00 idle |
| rsp_fifo_o | output | 8 | Per-port granted FIFO index, 2 bits per port |
| rsp_count_o | output | 48 | Per-port accepted word count, 12 bits per port |

## Verification
Two ports can request in the same cycle, and both can be limited to the same single FIFO. Arbitration and allocation then interact directly. The bench provokes this by raising both requests on one edge with both ports set to level 0, so only FIFO 0 is permitted. It checks that port 0 receives a full grant of FIFO 0, and that port 1 receives a wait one cycle later because FIFO 0 is by then held. Port 1 is then served once port 0 releases the FIFO.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [1:0] {
    RSP_NONE = 2'b00,
    RSP_OK   = 2'b01,
    RSP_PART = 2'b10,
    RSP_WAIT = 2'b11
  } rsp_code_e;
endpackage

// File: rtl/fa_prio_bank.sv
module fa_prio_bank #(
  parameter int N_PORTS = 4,
  parameter int LVL_W   = 2,
  parameter logic [LVL_W-1:0] RST_LVL = '1,
  localparam int PORT_W = $clog2(N_PORTS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [PORT_W-1:0]        addr_i,
  input  logic [LVL_W-1:0]         data_i,
  output logic [N_PORTS*LVL_W-1:0] level_o
);
  for (genvar p = 0; p < N_PORTS; p++) begin : g_lvl
    logic [LVL_W-1:0] lvl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                lvl_q <= RST_LVL;
      else if (we_i && addr_i == PORT_W'(p))      lvl_q <= data_i;
    end
    assign level_o[p*LVL_W +: LVL_W] = lvl_q;

    // R1: a host write lands in the addressed port's level
    a_r1_level_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == PORT_W'(p)) |=> (lvl_q == $past(data_i)));
  end
endmodule

// File: rtl/fa_port_arb.sv
module fa_port_arb #(
  parameter int N_PORTS = 4,
  localparam int PORT_W = $clog2(N_PORTS)
) (
  input  logic [N_PORTS-1:0] req_i,
  output logic [N_PORTS-1:0] gnt_o,
  output logic               any_o,
  output logic [PORT_W-1:0]  idx_o
);
  // fixed order, lowest index wins
  always_comb begin
    gnt_o = '0;
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      if (req_i[i] && !any_o) begin
        any_o    = 1'b1;
        gnt_o[i] = 1'b1;
        idx_o    = PORT_W'(i);
      end
    end
  end
endmodule

// File: rtl/fa_fifo_pick.sv
module fa_fifo_pick import fa_pkg::*; #(
  parameter int N_FIFOS = 4,
  parameter int CNT_W   = 12,
  localparam int LVL_W  = $clog2(N_FIFOS)
) (
  input  logic [LVL_W-1:0]         level_i,
  input  logic [CNT_W-1:0]         count_i,
  input  logic [N_FIFOS*CNT_W-1:0] free_i,
  input  logic [N_FIFOS-1:0]       busy_i,
  output rsp_code_e                code_o,
  output logic [LVL_W-1:0]         fifo_o,
  output logic [CNT_W-1:0]         cnt_o
);
  logic             fit_found, best_v;
  logic [LVL_W-1:0] fit_idx, best_idx;
  logic [CNT_W-1:0] best_free;

  always_comb begin
    fit_found = 1'b0;
    fit_idx   = '0;
    best_v    = 1'b0;
    best_idx  = '0;
    best_free = '0;
    for (int f = 0; f < N_FIFOS; f++) begin
      logic [CNT_W-1:0] fr;
      logic             elig;
      fr   = free_i[f*CNT_W +: CNT_W];
      elig = (LVL_W'(f) <= level_i) && (fr != '0) && !busy_i[f];
      if (elig && !fit_found && fr >= count_i) begin
        fit_found = 1'b1;
        fit_idx   = LVL_W'(f);
      end
      // strict compare keeps the lowest index on ties
      if (elig && (!best_v || fr > best_free)) begin
        best_v    = 1'b1;
        best_idx  = LVL_W'(f);
        best_free = fr;
      end
    end
    if (fit_found) begin
      code_o = RSP_OK;
      fifo_o = fit_idx;
      cnt_o  = count_i;
    end else if (best_v) begin
      code_o = RSP_PART;
      fifo_o = best_idx;
      cnt_o  = best_free;
    end else begin
      code_o = RSP_WAIT;
      fifo_o = '0;
      cnt_o  = '0;
    end
  end
endmodule

// File: rtl/fifo_alloc_router.sv
module fifo_alloc_router import fa_pkg::*; #(
  parameter int N_PORTS = 4,
  parameter int N_FIFOS = 4,
  parameter int CNT_W   = 12,
  localparam int PORT_W = $clog2(N_PORTS),
  localparam int LVL_W  = $clog2(N_FIFOS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_PORTS-1:0]       req_valid_i,
  input  logic [N_PORTS*CNT_W-1:0] req_count_i,
  input  logic [N_PORTS-1:0]       done_i,
  input  logic [N_FIFOS*CNT_W-1:0] fifo_free_i,
  input  logic                     cfg_we_i,
  input  logic [PORT_W-1:0]        cfg_addr_i,
  input  logic [LVL_W-1:0]         cfg_data_i,
  output logic [N_PORTS-1:0]       rsp_valid_o,
  output logic [N_PORTS*2-1:0]     rsp_code_o,
  output logic [N_PORTS*LVL_W-1:0] rsp_fifo_o,
  output logic [N_PORTS*CNT_W-1:0] rsp_count_o
);
  logic [N_PORTS*LVL_W-1:0] level_flat;
  logic [N_PORTS-1:0]       pend, arb_gnt, owns, rsp_v_q;
  logic                     fire;
  logic [PORT_W-1:0]        arb_idx;
  logic [LVL_W-1:0]         sel_level, pick_fifo, fifo_q;
  logic [CNT_W-1:0]         sel_count, pick_cnt, cnt_q;
  rsp_code_e                pick_code, code_q;
  logic [N_FIFOS-1:0]       alloc_q;
  logic [PORT_W-1:0]        owner_q [N_FIFOS];

  fa_prio_bank #(.N_PORTS(N_PORTS), .LVL_W(LVL_W)) u_prio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .data_i  (cfg_data_i),
    .level_o (level_flat)
  );

  // ports in their response cycle or holding a FIFO are not arbitrated
  assign pend = req_valid_i & ~rsp_v_q & ~owns;

  fa_port_arb #(.N_PORTS(N_PORTS)) u_arb (
    .req_i (pend),
    .gnt_o (arb_gnt),
    .any_o (fire),
    .idx_o (arb_idx)
  );

  assign sel_level = level_flat[arb_idx*LVL_W +: LVL_W];
  assign sel_count = req_count_i[arb_idx*CNT_W +: CNT_W];

  fa_fifo_pick #(.N_FIFOS(N_FIFOS), .CNT_W(CNT_W)) u_pick (
    .level_i (sel_level),
    .count_i (sel_count),
    .free_i  (fifo_free_i),
    .busy_i  (alloc_q),
    .code_o  (pick_code),
    .fifo_o  (pick_fifo),
    .cnt_o   (pick_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_v_q <= '0;
      code_q  <= RSP_NONE;
      fifo_q  <= '0;
      cnt_q   <= '0;
    end else begin
      rsp_v_q <= arb_gnt;
      if (fire) begin
        code_q <= pick_code;
        fifo_q <= pick_fifo;
        cnt_q  <= pick_cnt;
      end
    end
  end

  for (genvar f = 0; f < N_FIFOS; f++) begin : g_alloc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        alloc_q[f] <= 1'b0;
        owner_q[f] <= '0;
      end else if (fire && pick_code != RSP_WAIT && pick_fifo == LVL_W'(f)) begin
        alloc_q[f] <= 1'b1;
        owner_q[f] <= arb_idx;
      end else if (alloc_q[f] && done_i[owner_q[f]]) begin
        alloc_q[f] <= 1'b0;
      end
    end
  end

  always_comb begin
    owns = '0;
    for (int p = 0; p < N_PORTS; p++)
      for (int f = 0; f < N_FIFOS; f++)
        if (alloc_q[f] && owner_q[f] == PORT_W'(p)) owns[p] = 1'b1;
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_out
    assign rsp_valid_o[p]               = rsp_v_q[p];
    assign rsp_code_o[p*2 +: 2]         = rsp_v_q[p] ? code_q : RSP_NONE;
    assign rsp_fifo_o[p*LVL_W +: LVL_W] = rsp_v_q[p] ? fifo_q : '0;
    assign rsp_count_o[p*CNT_W +: CNT_W] = rsp_v_q[p] ? cnt_q : '0;
  end

  // R7: one response per cycle
  a_r7_one_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rsp_v_q));

  // R2: grant never above the port's level
  a_r2_level_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && pick_code != RSP_WAIT) |-> (pick_fifo <= sel_level));

  // R4: partial grant is non-zero and below the request
  a_r4_part_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && pick_code == RSP_PART) |-> (pick_cnt < sel_count && pick_cnt != '0));

  // R8: a granted FIFO is held from the next cycle
  a_r8_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && pick_code != RSP_WAIT) |=> alloc_q[$past(pick_fifo)]);

  // R6: a held FIFO is never granted again
  a_r6_no_double: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && pick_code != RSP_WAIT) |-> !alloc_q[pick_fifo]);
endmodule

// File: tb/sim_fifo_alloc_router.sv
module sim_fifo_alloc_router;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int CW = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP-1:0]     req_valid = '0;
  logic [NP*CW-1:0]  req_count = '0;
  logic [NP-1:0]     done = '0;
  logic [4*CW-1:0]   fifo_free = '0;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_addr = '0;
  logic [1:0]        cfg_data = '0;
  logic [NP-1:0]     rsp_valid;
  logic [NP*2-1:0]   rsp_code;
  logic [NP*2-1:0]   rsp_fifo;
  logic [NP*CW-1:0]  rsp_count;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_alloc_router u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_count_i(req_count),
    .done_i(done), .fifo_free_i(fifo_free), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_data_i(cfg_data), .rsp_valid_o(rsp_valid), .rsp_code_o(rsp_code),
    .rsp_fifo_o(rsp_fifo), .rsp_count_o(rsp_count)
  );

  // port, level, free0..free3, request, exp code, exp fifo, exp count
  localparam int VW = 80;
  localparam logic [VW-1:0] VEC [8] = '{
    {2'd0, 2'd3, 12'd100, 12'd100, 12'd100, 12'd100, 12'd50,   2'b01, 2'd0, 12'd50},
    {2'd1, 2'd3, 12'd10,  12'd60,  12'd100, 12'd100, 12'd50,   2'b01, 2'd1, 12'd50},
    {2'd2, 2'd1, 12'd10,  12'd20,  12'd100, 12'd100, 12'd50,   2'b10, 2'd1, 12'd20},
    {2'd3, 2'd0, 12'd0,   12'd100, 12'd100, 12'd100, 12'd5,    2'b11, 2'd0, 12'd0},
    {2'd0, 2'd2, 12'd30,  12'd30,  12'd5,   12'd100, 12'd40,   2'b10, 2'd0, 12'd30},
    {2'd1, 2'd3, 12'd0,   12'd0,   12'd0,   12'd7,   12'd7,    2'b01, 2'd3, 12'd7},
    {2'd2, 2'd2, 12'd0,   12'd0,   12'd0,   12'd900, 12'd5,    2'b11, 2'd0, 12'd0},
    {2'd3, 2'd3, 12'd4095,12'd4095,12'd4095,12'd4095,12'd4095, 2'b01, 2'd0, 12'd4095}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_rsp(input int p, input logic [1:0] c, input logic [1:0] f,
                           input logic [11:0] n, input string req);
    check(rsp_valid == NP'(1 << p), req, "valid", int'(rsp_valid), 1 << p);
    check(rsp_code[p*2 +: 2] == c, req, "code", int'(rsp_code[p*2 +: 2]), int'(c));
    check(rsp_fifo[p*2 +: 2] == f, req, "fifo", int'(rsp_fifo[p*2 +: 2]), int'(f));
    check(rsp_count[p*CW +: CW] == n, req, "count", int'(rsp_count[p*CW +: CW]), int'(n));
  endtask

  task automatic cfg_write(input int p, input logic [1:0] lvl);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(p); cfg_data = lvl;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // raise a request, land at the negedge after the response edge
  task automatic request(input int p, input logic [11:0] n);
    @(negedge clk);
    req_valid[p] = 1'b1;
    req_count[p*CW +: CW] = n;
    @(negedge clk);
  endtask

  task automatic release_port(input int p);
    @(negedge clk);
    done[p] = 1'b1;
    @(negedge clk);
    done[p] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(rsp_valid == '0, "R10", "valid", int'(rsp_valid), 0);
    check(rsp_code == '0 && rsp_count == '0, "R10", "fields", int'(rsp_code), 0);
    rst_n = 1'b1;

    // R1: reset level 3 lets port 3 reach FIFO 3
    fifo_free = {12'd50, 12'd0, 12'd0, 12'd0};
    request(3, 12'd10);
    check_rsp(3, 2'b01, 2'd3, 12'd10, "R1");
    req_valid[3] = 1'b0;
    release_port(3);

    // R2 R3 R4 R5 R6: table of single-port requests
    for (int i = 0; i < 8; i++) begin
      logic [VW-1:0] v;
      int p;
      v = VEC[i];
      p = int'(v[79:78]);
      cfg_write(p, v[77:76]);
      fifo_free = {v[39:28], v[51:40], v[63:52], v[75:64]};
      request(p, v[27:16]);
      check_rsp(p, v[15:14], v[13:12], v[11:0], "R2_R3_R4_R5_R6");
      req_valid[p] = 1'b0;
      if (v[15:14] != 2'b11) release_port(p);
      else @(negedge clk);
    end

    // R7: simultaneous requests, both limited to FIFO 0
    cfg_write(0, 2'd0);
    cfg_write(1, 2'd0);
    fifo_free = {12'd100, 12'd100, 12'd100, 12'd100};
    @(negedge clk);
    req_valid[1:0] = 2'b11;
    req_count[0 +: CW] = 12'd10;
    req_count[CW +: CW] = 12'd20;
    @(negedge clk);
    check_rsp(0, 2'b01, 2'd0, 12'd10, "R7");
    req_valid[0] = 1'b0;
    @(negedge clk);
    check_rsp(1, 2'b11, 2'd0, 12'd0, "R7");
    req_valid[1] = 1'b0;

    // R9: holder's new request gets no response
    @(negedge clk);
    req_valid[0] = 1'b1;
    repeat (3) @(negedge clk);
    check(rsp_valid == '0, "R9", "valid", int'(rsp_valid), 0);
    req_valid[0] = 1'b0;

    // R8: release frees FIFO 0 for port 1
    release_port(0);
    request(1, 12'd20);
    check_rsp(1, 2'b01, 2'd0, 12'd20, "R8");
    req_valid[1] = 1'b0;
    @(negedge clk);
    check(rsp_valid == '0, "R7", "pulse width", int'(rsp_valid), 0);
    release_port(1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule